// File: doc/BRIEF.md
# Link Sideband Flags Register

This block is one 32-bit control and status word for a serial data link. Software writes it to set four outgoing sideband levels and to ask the transmitter for a single SYNC marker that carries no data. It reads the same word to see the four sideband levels arriving from the far end, live flow-control and overflow indications, and sticky records of those events, so that a brief event is not missed between two polls.

Address decode happens outside. The block sees a select, a write strobe, a read strobe and write data, and returns read data one cycle after a read. Every input that comes from the link side is taken through a two-stage synchronizer before it is reported or latched. A separate link-control register supplies a one-cycle pulse that clears the received-SYNC record. The three sticky event bits clear when software writes 0 to them, and an event that is still present wins over the clear.

Top module: `lsf_flags_reg`

## Requirements
- R1: Out of reset, reg_rdata, sync_send_o and sb_out_o are all 0, and a first read with all link inputs low returns 0.
- R2: A write with bit 0 set raises sync_send_o for exactly one cycle, the cycle after the write edge. A write with bit 0 clear gives no pulse, and bit 0 always reads 0.
- R3: Bits 4:1 are read/write and drive sb_out_o[3:0] (bit 1 to sb_out_o[0]). They change only on a write.
- R4: Bit 8 sets when the synchronized sync_rx_i is 1 and stays set until a sync_clr_i pulse. If sync_rx_i is still high in the clearing cycle, the bit stays set.
- R5: Bits 12:9 read the synchronized sb_in_i[3:0] (bit 9 from sb_in_i[0]).
- R6: Bits 13, 14 and 15 read the synchronized stop_rx_i, stop_tx_i and ovf_rx_i, live, with no memory.
- R7: Bits 16, 17 and 18 are sticky copies of bits 13, 14 and 15. Each sets while its source is 1 and clears on a write with a 0 in that position. A write with a 1 there changes nothing.
- R8: When a sticky bit's source is 1 in the same cycle that a write clears it, the bit stays 1.
- R9: Bits 0, 7:5 and 31:19 always read 0. Writes to the read-only positions 8 to 15 have no effect.
- R10: A change on a link input is first seen by a read whose strobe is sampled on the third rising edge after the change. A read sampled on the first or second edge still returns the old value.
- R11: reg_rdata is loaded on the rising edge that samples reg_sel and reg_rd both high, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | This register is addressed |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sync_send_o | output | 1 | One-cycle request to send a data-less SYNC |
| sb_out_o | output | 4 | Outgoing sideband levels: gpio A, gpio B, direction, not-ready |
| sb_in_i | input | 4 | Sideband levels received from the far end, same order |
| sync_rx_i | input | 1 | Data-less SYNC received indication |
| stop_rx_i | input | 1 | STOP flow-control being received |
| stop_tx_i | input | 1 | STOP flow-control being sent |
| ovf_rx_i | input | 1 | Far-end transmit overflow flag from received frame status |
| sync_clr_i | input | 1 | Clear pulse for the received-SYNC bit |

## Verification
A sticky bit that fails to set, or that clears while its source is still high, shows on the next read as a 0 where a 1 belongs in bits 8 or 16 to 18. Such a read can be issued three edges after the event. A synchronizer with too few or too many stages moves the point at which a changed input first appears in the read word by one read, and this is checked edge by edge. A lost or stretched SYNC request shows on sync_send_o in the very cycle after the write. A corrupted sideband output register shows on sb_out_o at once, and again on the next read.

// File: rtl/lsf_pkg.sv
// Package: shared bit positions, widths and the link-input bundle for the
// sideband flags register. Assumes the fixed 32-bit word layout below.
package lsf_pkg;
    localparam int REG_W         = 32;
    localparam int SB_W          = 4;   // outgoing/incoming sideband lines
    localparam int EVT_W         = 3;   // stop_rx, stop_tx, overflow
    localparam int BIT_SYNC_TX   = 0;
    localparam int BIT_SB_OUT_LO = 1;
    localparam int BIT_SYNC_RX   = BIT_SB_OUT_LO + SB_W + 3;   // 8
    localparam int BIT_SB_IN_LO  = BIT_SYNC_RX + 1;            // 9
    localparam int BIT_LIVE_LO   = BIT_SB_IN_LO + SB_W;        // 13
    localparam int BIT_LAT_LO    = BIT_LIVE_LO + EVT_W;        // 16
    localparam int BIT_TOP_USED  = BIT_LAT_LO + EVT_W - 1;     // 18

    // Positions that carry information on a read; all others read zero.
    localparam logic [REG_W-1:0] USED_MASK =
        ((REG_W'(1) << (BIT_TOP_USED + 1)) - (REG_W'(1) << BIT_SYNC_RX)) |
        (((REG_W'(1) << SB_W) - REG_W'(1)) << BIT_SB_OUT_LO);

    // Inputs from the link clock domain, bundled for one synchronizer.
    typedef struct packed {
        logic [EVT_W-1:0] evt;      // [0] stop_rx, [1] stop_tx, [2] overflow
        logic             sync_rx;
        logic [SB_W-1:0]  sb;
    } link_in_t;
endpackage

// File: rtl/lsf_sync.sv
// Module: multi-bit, multi-stage flop synchronizer.
// Assumes each bit is an independent level; no bus coherency is implied.
module lsf_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stage: shift from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end

            assert_stage_shift_R10: assert property (@(posedge clk)
                disable iff (!rst_n) $past(rst_n) |-> stg[i] == $past(stg[i-1]));
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/lsf_sticky.sv
// Module: vector of sticky event bits. A set input wins over a clear input
// in the same cycle. Assumes set and clear are already synchronous.
module lsf_sticky #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    // Hold, clear, or set with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= set_i | (q_o & ~clr_i);
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q_o & $past(set_i)) == $past(set_i)));

    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q_o & $past(clr_i & ~set_i)) == '0));

    assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/lsf_flags_reg.sv
// Module: link sideband flags register (top). Drives outgoing sideband
// levels and a one-shot SYNC request; reports synchronized remote sideband
// levels, live link status and sticky event copies. Assumes address decode
// is external and sync_clr_i is a single-cycle pulse in the clk domain.
module lsf_flags_reg
    import lsf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sync_send_o,
    output logic [SB_W-1:0]  sb_out_o,
    input  logic [SB_W-1:0]  sb_in_i,
    input  logic             sync_rx_i,
    input  logic             stop_rx_i,
    input  logic             stop_tx_i,
    input  logic             ovf_rx_i,
    input  logic             sync_clr_i
);
    localparam int LINK_W = $bits(link_in_t);

    logic             wr_en;
    logic             rd_en;
    link_in_t         link_raw;
    link_in_t         link_syn;
    logic [EVT_W-1:0] lat_clr;
    logic [EVT_W-1:0] lat_q;
    logic             sync_seen;
    logic [REG_W-1:0] rd_word;

    assign wr_en = reg_sel & reg_wr;
    assign rd_en = reg_sel & reg_rd;

    // Bundle link-domain inputs for the synchronizer.
    always_comb begin
        link_raw.sb      = sb_in_i;
        link_raw.sync_rx = sync_rx_i;
        link_raw.evt     = {ovf_rx_i, stop_tx_i, stop_rx_i};
    end

    lsf_sync #(.W(LINK_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (link_raw),
        .q     (link_syn)
    );

    // Outgoing sideband levels: loaded only by a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     sb_out_o <= '0;
        else if (wr_en) sb_out_o <= reg_wdata[BIT_SB_OUT_LO +: SB_W];
    end

    // One-cycle SYNC request on a write of 1 to the request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_send_o <= 1'b0;
        else        sync_send_o <= wr_en & reg_wdata[BIT_SYNC_TX];
    end

    lsf_sticky #(.W(1)) i_sync_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (link_syn.sync_rx),
        .clr_i (sync_clr_i),
        .q_o   (sync_seen)
    );

    // Software clears a sticky event bit by writing 0 to its position.
    assign lat_clr = {EVT_W{wr_en}} & ~reg_wdata[BIT_LAT_LO +: EVT_W];

    lsf_sticky #(.W(EVT_W)) i_evt_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (link_syn.evt),
        .clr_i (lat_clr),
        .q_o   (lat_q)
    );

    // Assemble the read word; unused positions stay zero.
    always_comb begin
        rd_word                            = '0;
        rd_word[BIT_SB_OUT_LO +: SB_W]     = sb_out_o;
        rd_word[BIT_SYNC_RX]               = sync_seen;
        rd_word[BIT_SB_IN_LO +: SB_W]      = link_syn.sb;
        rd_word[BIT_LIVE_LO +: EVT_W]      = link_syn.evt;
        rd_word[BIT_LAT_LO +: EVT_W]       = lat_q;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     reg_rdata <= '0;
        else if (rd_en) reg_rdata <= rd_word;
    end

    assert_sync_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_send_o |=> !sync_send_o);

    assert_sync_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) |-> !sync_send_o);

    assert_sb_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) |-> $stable(sb_out_o));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~USED_MASK) == '0);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rd_en) |-> $stable(reg_rdata));
endmodule

// File: tb/test_lsf_flags_reg.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a bench-side model of the register word.
module test_lsf_flags_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_sel, reg_wr, reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sync_send_o;
    logic [3:0]  sb_out_o;
    logic [3:0]  sb_in_i;
    logic        sync_rx_i, stop_rx_i, stop_tx_i, ovf_rx_i, sync_clr_i;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [3:0] m_so;
    logic       m_sf;
    logic [2:0] m_lat;

    always #5 clk = ~clk;

    lsf_flags_reg i_lsf_flags_reg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sync_send_o(sync_send_o), .sb_out_o(sb_out_o), .sb_in_i(sb_in_i),
        .sync_rx_i(sync_rx_i), .stop_rx_i(stop_rx_i), .stop_tx_i(stop_tx_i),
        .ovf_rx_i(ovf_rx_i), .sync_clr_i(sync_clr_i)
    );

    function automatic logic [31:0] exp_word(input logic [3:0] so, input logic [3:0] si,
                                             input logic sf, input logic [2:0] live,
                                             input logic [2:0] lat);
        logic [31:0] w = '0;
        w[4:1]   = so;
        w[8]     = sf;
        w[12:9]  = si;
        w[15:13] = live;
        w[18:16] = lat;
        return w;
    endfunction

    function automatic logic [2:0] cur_live();
        return {ovf_rx_i, stop_tx_i, stop_rx_i};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // All tasks enter and leave at a falling edge.
    task automatic do_write(input logic [31:0] w);
        reg_sel = 1; reg_wr = 1; reg_wdata = w;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0;
        check("R2 pulse", {31'b0, sync_send_o}, {31'b0, w[0]});
        @(negedge clk);
        check("R2 single", {31'b0, sync_send_o}, 32'b0);
        m_so  = w[4:1];
        m_lat = (m_lat & w[18:16]) | cur_live();
    endtask

    task automatic do_read(output logic [31:0] r);
        reg_sel = 1; reg_rd = 1;
        @(negedge clk);
        reg_sel = 0; reg_rd = 0;
        r = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        m_lat = m_lat | cur_live();
        if (sync_rx_i) m_sf = 1'b1;
    endtask

    task automatic pulse_clr();
        sync_clr_i = 1;
        @(negedge clk);
        sync_clr_i = 0;
        m_sf = sync_rx_i;
        @(negedge clk);
    endtask

    task automatic read_check(input string req);
        logic [31:0] r;
        do_read(r);
        check(req, r, exp_word(m_so, sb_in_i, m_sf, cur_live(), m_lat));
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r, held;
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 0; reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        sb_in_i = '0; sync_rx_i = 0; stop_rx_i = 0; stop_tx_i = 0; ovf_rx_i = 0;
        sync_clr_i = 0;
        m_so = '0; m_sf = 0; m_lat = '0;
        repeat (4) @(negedge clk);
        check("R1 rdata", reg_rdata, 32'b0);
        check("R1 sync_send", {31'b0, sync_send_o}, 32'b0);
        check("R1 sb_out", {28'b0, sb_out_o}, 32'b0);
        rst_n = 1;
        @(negedge clk);
        do_read(r);
        check("R1 first read", r, 32'b0);

        // R2: request bit alone, then a write of 0
        do_write(32'h1);
        read_check("R2 bit0 reads 0");
        do_write(32'h0);

        // R3: sideband outputs
        do_write(32'h0000_0014);
        check("R3 sb_out", {28'b0, sb_out_o}, 32'ha);
        read_check("R3 readback");

        // R10 and R5: latency of a link input change
        sb_in_i = 4'b0110;
        do_read(r);
        check("R10 edge1 old", {28'b0, r[12:9]}, 32'h0);
        do_read(r);
        check("R10 edge2 old", {28'b0, r[12:9]}, 32'h0);
        do_read(r);
        check("R5 R10 edge3 new", {28'b0, r[12:9]}, 32'h6);

        // R6, R7, R8: stop received, sticky copy, clear while still active
        stop_rx_i = 1;
        settle();
        read_check("R6 R7 live and latched");
        do_write({13'b0, 3'b000, 11'b0, m_so, 1'b0});
        read_check("R8 set wins over clear");
        stop_rx_i = 0;
        settle();
        read_check("R7 stays latched");
        do_write({13'b0, 3'b111, 11'b0, m_so, 1'b0});
        read_check("R7 write 1 no effect");
        check("R7 still set", {31'b0, m_lat[0]}, 32'h1);
        do_write({13'b0, 3'b000, 11'b0, m_so, 1'b0});
        read_check("R7 cleared");

        // R4: received SYNC flag
        sync_rx_i = 1;
        settle();
        sync_rx_i = 0;
        settle();
        read_check("R4 sticky set");
        sync_rx_i = 1;
        settle();
        pulse_clr();
        read_check("R4 set wins over clear");
        sync_rx_i = 0;
        settle();
        pulse_clr();
        read_check("R4 cleared");

        // R9: all-ones write touches only writable bits
        do_write(32'hffff_fffe);
        read_check("R9 reserved and read-only");
        do_write(32'h0000_0000);

        // R11: rdata holds without a read strobe
        do_read(held);
        sb_in_i = 4'b1001; stop_tx_i = 1;
        repeat (5) @(negedge clk);
        check("R11 hold", reg_rdata, held);
        settle();
        read_check("R11 R6 after strobe");

        // Random traffic
        for (int i = 0; i < 300; i++) begin
            sb_in_i   = 4'($urandom);
            stop_rx_i = 1'($urandom);
            stop_tx_i = 1'($urandom);
            ovf_rx_i  = 1'($urandom);
            sync_rx_i = ($urandom % 4) == 0;
            settle();
            if ($urandom % 2) begin
                logic [31:0] w = $urandom;
                do_write(w);
                check("R3 random sb_out", {28'b0, sb_out_o}, {28'b0, m_so});
            end
            if ($urandom % 3 == 0) pulse_clr();
            read_check("R5 R6 R7 R8 R9 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule